// File: doc/BRIEF.md
# Iterative Shift-and-Add Integer Multiplier

This block multiplies two 32-bit integers over a fixed number of clock cycles. It uses one narrow adder instead of a full array. The multiplicand is captured once and stays in its own register. A single double-width accumulator register holds two things: the growing partial product in its upper half and the not-yet-consumed multiplier bits in its lower half. On every step the adder may add the multiplicand into the upper half, depending on the lowest accumulator bit. The whole accumulator then moves right by one place. The adder's carry enters at the top bit.

For signed operation, each negative operand is first turned into its magnitude. The magnitudes are multiplied as unsigned values. One extra cycle then negates the 64-bit result if the operand signs differ. The result is read as two 32-bit words, `hi` and `lo`.

The issuing side presents the operands and a one-cycle `start`. There is no stall handshake: `busy` acts as the not-ready indication. A `start` seen while `busy` is high is dropped, not held, so the issuer must wait for `busy` low before it offers the next operation. `done` marks the single cycle in which the result first becomes valid. A new `start` may be offered in that same cycle.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `hi` and `lo` are both zero.
- R2: With `is_signed` = 0, `{hi,lo}` equals the unsigned 64-bit product of `op_a` and `op_b` when `done` is high.
- R3: With `is_signed` = 1, `{hi,lo}` equals the two's complement 64-bit product, including operands of value 0x80000000 (the most negative number).
- R4: Carries out of the 32-bit adder are kept: 0xFFFFFFFF times 0xFFFFFFFF unsigned gives 0xFFFFFFFE_00000001.
- R5: A `start` sampled with `busy` low at clock edge k is accepted, and `done` is high in the cycle that follows edge k+33 (32 add/shift steps plus one sign fix-up step).
- R6: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance through the cycle before `done`, and it is low while `done` is high.
- R7: A `start` sampled while `busy` is high is ignored: the running operation keeps its operands, its result and its timing.
- R8: `hi` and `lo` stay unchanged from the `done` cycle until the next accepted `start`, whatever the operand inputs do.
- R9: A `start` offered in the same cycle as `done` is accepted and produces its own correct result 33 cycles later.
- R10: Operands and `is_signed` are sampled only at the accepting edge; later changes on those inputs do not affect the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply; accepted when `busy` is low |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| busy | output | 1 | Operation in progress; new starts are dropped |
| done | output | 1 | One-cycle pulse: result valid on `hi`/`lo` |
| hi | output | 32 | Upper 32 bits of the product |
| lo | output | 32 | Lower 32 bits of the product |

## Verification
The completion of one operation and the acceptance of the next can happen in the same cycle. In that cycle `done` is high, `busy` is already low, and a new `start` is being offered. The bench provokes this by raising `start` with fresh operands in the very cycle it sees `done`. It first checks that the finishing result is still on `hi`/`lo` during that cycle. It then checks that the second product arrives exactly 33 cycles later with its own correct value. A second overlap, a dropped `start` arriving during a running operation, is judged by checking that neither the first result nor its completion cycle moves.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_operand_prep.sv
// Converts operands to magnitudes when signed mode is selected and
// reports whether the final product must be negated.
module mul_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         sgn_mode,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         flip_result
);
  logic neg_a;
  logic neg_b;

  assign neg_a = sgn_mode & in_a[W-1];
  assign neg_b = sgn_mode & in_b[W-1];

  // 0x80..0 maps onto itself, which is the correct unsigned magnitude.
  assign mag_a = neg_a ? (~in_a + W'(1)) : in_a;
  assign mag_b = neg_b ? (~in_b + W'(1)) : in_b;
  assign flip_result = neg_a ^ neg_b;
endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: one load cycle, W add/shift steps, one sign fix-up step.
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic fix,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  mul_state_e      state_q;
  mul_state_e      state_d;
  logic [CW-1:0]   cnt_q;
  logic            last_step;
  logic            done_q;

  assign last_step = (cnt_q == CW'(W - 1));
  assign load = (state_q == ST_IDLE) && start;
  assign step = (state_q == ST_RUN);
  assign fix  = (state_q == ST_FIX);
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)     state_d = ST_RUN;
      ST_RUN:  if (last_step) state_d = ST_FIX;
      ST_FIX:                 state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fix;
      if (load)      cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mul_datapath.sv
// Fixed multiplicand, W-bit adder, shared 2W-bit product/multiplier register.
module mul_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         fix,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  input  logic         flip_in,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] acc_q;
  logic          flip_q;
  logic [W-1:0]  addend;
  logic [W:0]    partial;

  // Add the multiplicand into the upper half only when the current
  // multiplier bit (accumulator LSB) is set; keep the carry as bit W.
  assign addend  = acc_q[0] ? mcand_q : '0;
  assign partial = {1'b0, acc_q[PW-1:W]} + {1'b0, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      acc_q   <= '0;
      flip_q  <= 1'b0;
    end else if (load) begin
      mcand_q <= mag_a;
      acc_q   <= {{W{1'b0}}, mag_b};
      flip_q  <= flip_in;
    end else if (step) begin
      acc_q <= {partial, acc_q[W-1:1]};
    end else if (fix && flip_q) begin
      acc_q <= ~acc_q + PW'(1);
    end
  end

  assign prod_hi = acc_q[PW-1:W];
  assign prod_lo = acc_q[W-1:0];
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         is_signed,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [W-1:0] mag_a;
  logic [W-1:0] mag_b;
  logic         flip;
  logic         load;
  logic         step;
  logic         fix;

  mul_operand_prep #(.W(W)) u_prep (
    .in_a        (op_a),
    .in_b        (op_b),
    .sgn_mode    (is_signed),
    .mag_a       (mag_a),
    .mag_b       (mag_b),
    .flip_result (flip)
  );

  mul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .fix   (fix),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .fix     (fix),
    .mag_a   (mag_a),
    .mag_b   (mag_b),
    .flip_in (flip),
    .prod_hi (hi),
    .prod_lo (lo)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int LW = $clog2(W + 4) + 1;

  logic [LW-1:0] since_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_accept <= '0;
    else if (start && !busy)  since_accept <= '0;
    else if (busy)            since_accept <= since_accept + LW'(1);
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_accept == LW'(W + 1)));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({hi, lo}));
endmodule

bind shift_add_mul mul_chk #(.W(W)) u_mul_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .hi    (hi),
  .lo    (lo)
);

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;
  localparam int W = 32;
  localparam int LAT = W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         is_signed = 1'b0;
  logic         busy;
  logic         done;
  logic [W-1:0] hi;
  logic [W-1:0] lo;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  shift_add_mul #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .is_signed(is_signed), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic signed [63:0] sa;
    logic signed [63:0] sb;
    if (s) begin
      sa = $signed(a);
      sb = $signed(b);
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; the next posedge is the accepting edge.
  task automatic issue(logic [W-1:0] a, logic [W-1:0] b, logic s);
    start = 1'b1; op_a = a; op_b = b; is_signed = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_done(inout int cyc);
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_op(string tag, logic [W-1:0] a, logic [W-1:0] b, logic s);
    int cyc = 0;
    issue(a, b, s);
    check_int({tag, " R6 busy after accept"}, int'(busy), 1);
    await_done(cyc);
    check_int({tag, " R5 latency"}, cyc, LAT);
    check64(tag, {hi, lo}, ref_prod(a, b, s));
    @(negedge clk);
    check_int({tag, " R6 done single cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    check_int("R1 busy", int'(busy), 0);
    check_int("R1 done", int'(done), 0);
    check64("R1 product", {hi, lo}, 64'h0);
  endtask

  task automatic t_unsigned();
    run_op("R2 zero", 32'h0, 32'h1234_5678, 1'b0);
    run_op("R2 one", 32'h1, 32'hDEAD_BEEF, 1'b0);
    run_op("R4 ones x ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check64("R4 explicit", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
    run_op("R2 msb", 32'h8000_0000, 32'h8000_0000, 1'b0);
    for (int i = 0; i < 6; i++) run_op("R2 random", $urandom, $urandom, 1'b0);
  endtask

  task automatic t_signed();
    run_op("R3 minneg sq", 32'h8000_0000, 32'h8000_0000, 1'b1);
    run_op("R3 minneg x1", 32'h8000_0000, 32'h1, 1'b1);
    run_op("R3 minneg x-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    run_op("R3 -1 x -1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    run_op("R3 -1 x 1", 32'hFFFF_FFFF, 32'h1, 1'b1);
    run_op("R3 zero x neg", 32'h0, 32'hFFFF_FFF0, 1'b1);
    for (int i = 0; i < 6; i++) run_op("R3 random", $urandom, $urandom, 1'b1);
  endtask

  task automatic t_ignore_busy();
    int cyc = 0;
    issue(32'h0001_0003, 32'hFFFF_FFFB, 1'b1);
    repeat (9) begin @(negedge clk); cyc++; end
    start = 1'b1; op_a = 32'h7777_7777; op_b = 32'h5; is_signed = 1'b0;
    @(negedge clk); cyc++;
    start = 1'b0;
    op_a = 32'hAAAA_AAAA; op_b = 32'h5555_5555; is_signed = 1'b0; // R10
    await_done(cyc);
    check_int("R7 latency unchanged", cyc, LAT);
    check64("R7 R10 result kept", {hi, lo}, ref_prod(32'h0001_0003, 32'hFFFF_FFFB, 1'b1));
    @(negedge clk);
    check_int("R7 no second done", int'(done), 0);
    repeat (LAT) @(negedge clk);
    check_int("R7 not busy", int'(busy), 0);
  endtask

  task automatic t_hold();
    logic [63:0] kept;
    run_op("R8 setup", 32'h0BAD_F00D, 32'h0000_1001, 1'b0);
    kept = {hi, lo};
    for (int i = 0; i < 5; i++) begin
      op_a = $urandom; op_b = $urandom; is_signed = ~is_signed;
      @(negedge clk);
    end
    check64("R8 hold", {hi, lo}, kept);
  endtask

  task automatic t_back_to_back();
    int cyc = 0;
    issue(32'hFFFF_FFFE, 32'h0000_0003, 1'b1);
    await_done(cyc);
    check64("R9 first result", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFA);
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b0);
    check_int("R9 accepted in done cycle", int'(busy), 1);
    cyc = 0;
    await_done(cyc);
    check_int("R9 latency", cyc, LAT);
    check64("R9 second result", {hi, lo}, ref_prod(32'h1234_5678, 32'h9ABC_DEF0, 1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_ignore_busy();
    t_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule